// File: doc/BRIEF.md
# Tag-Matching Reservation Station Array

This block schedules arithmetic operations out of order using tags. It has one pool of waiting stations for addition and one for multiplication, a register status table and a single shared result bus. A dispatched operation is placed in a free station of the matching unit type. Each source operand is taken either as a ready value or as the tag of the station that will produce it. The destination register is then marked as pending on the new station's tag.

Stations and register entries watch the result bus. When a pending slot sees its own tag, it copies the broadcast value. A station whose two operands are present is handed to its group's execution stub. The stub has a fixed latency and is not pipelined. When it finishes, the stub asks for the bus. The station stays occupied until its result has been broadcast, so a tag always names exactly one outstanding producer.

Tags are numbered from 1: the adder stations come first, then the multiplier stations. Tag 0 never names a producer.

Top module: `tag_station_array`

## Requirements
- R1: An accepted operation takes the lowest-index free station of its type. Its tag is 1..N_ADD for the adder group (disp_is_mul=0) and N_ADD+1..N_ADD+N_MUL for the multiplier group (disp_is_mul=1).
- R2: disp_ready is 1 exactly when the group chosen by disp_is_mul has a free station. While it is 0, disp_valid has no effect.
- R3: The cycle after an accepted dispatch, the destination register reads pending (rf_rpresent=0) with rf_rtag equal to the allocated tag.
- R4: A broadcast writes a pending register only if the register's tag equals the broadcast tag. A register whose tag was replaced by a later dispatch stays pending on the newer tag.
- R5: A station operand waiting on a tag takes the broadcast value and becomes present at the end of the cycle in which that tag is broadcast.
- R6: A source whose producer is broadcasting in the dispatch cycle itself is captured as a present value from the bus.
- R7: A station issues only when both operands are present and its group's unit is idle. Among the ready stations of a group, the lowest index issues first.
- R8: A result requests the bus exactly ADD_LAT (adder) or MUL_LAT (multiplier) cycles after its issue cycle. The value is the DW-bit sum or the low DW bits of the product.
- R9: At most one result is broadcast per cycle. The multiplier group wins when both groups request, and the losing result is held unchanged until it is granted.
- R10: A station is freed at the end of its broadcast cycle and can be allocated again from the next cycle.
- R11: After reset, every register i is present with value i, disp_ready is 1 and no result is broadcast.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| disp_valid | input | 1 | An operation is offered |
| disp_is_mul | input | 1 | 1: multiplier group, 0: adder group |
| disp_dst | input | $clog2(NREG) | Destination register |
| disp_src_a | input | $clog2(NREG) | First source register |
| disp_src_b | input | $clog2(NREG) | Second source register |
| disp_ready | output | 1 | A station of the requested type is free |
| cdb_valid | output | 1 | Result bus carries a result this cycle |
| cdb_tag | output | $clog2(N_ADD+N_MUL+1) | Tag of the broadcasting station |
| cdb_data | output | DW | Broadcast result value |
| rf_raddr | input | $clog2(NREG) | Register status observation address |
| rf_rpresent | output | 1 | Observed register holds a value |
| rf_rtag | output | $clog2(N_ADD+N_MUL+1) | Producer tag of the observed register |
| rf_rdata | output | DW | Value of the observed register |

## Verification
The bench builds the block with eight registers, 16-bit data, three adder stations, two multiplier stations, an adder latency of 2 and a multiplier latency of 3. With these values all adder stations can be filled within three cycles, so stalls and the reuse of a station are reached quickly. The different latencies also let an adder and a multiplier result request the bus in the same cycle, which exercises the bus priority. Directed sequences set up a dispatch in the same cycle as its producer's broadcast, and a register whose tag is overwritten before the older result arrives. A long random stream then keeps many operands waiting on tags at once.

// File: rtl/tsa_pkg.sv
// Shared definitions for the tag-matching station array.
// Assumes: tag value 0 is never allocated to a station.
package tsa_pkg;

    typedef enum logic {
        UNIT_ADD = 1'b0,
        UNIT_MUL = 1'b1
    } unit_kind_e;

    // Bits needed to number n producers plus the reserved value 0.
    function automatic int tag_bits(input int n);
        return $clog2(n + 1);
    endfunction

endpackage

// File: rtl/tsa_reg_status.sv
// Register status table. Each entry is either present (holds a value) or
// pending on the tag of the station that will write it. Pending entries
// snoop the result bus and take the value on a tag match. A dispatch that
// renames an entry overrides a broadcast to the same entry in that cycle.
// Assumes: set_en is only raised for an accepted dispatch.
module tsa_reg_status #(
    parameter int NREG = 8,
    parameter int DW   = 16,
    parameter int TW   = 3
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [$clog2(NREG)-1:0] rd_a_addr,
    output logic                    rd_a_present,
    output logic [TW-1:0]           rd_a_tag,
    output logic [DW-1:0]           rd_a_val,
    input  logic [$clog2(NREG)-1:0] rd_b_addr,
    output logic                    rd_b_present,
    output logic [TW-1:0]           rd_b_tag,
    output logic [DW-1:0]           rd_b_val,
    input  logic [$clog2(NREG)-1:0] rd_o_addr,
    output logic                    rd_o_present,
    output logic [TW-1:0]           rd_o_tag,
    output logic [DW-1:0]           rd_o_val,
    input  logic                    set_en,
    input  logic [$clog2(NREG)-1:0] set_addr,
    input  logic [TW-1:0]           set_tag,
    input  logic                    cdb_valid,
    input  logic [TW-1:0]           cdb_tag,
    input  logic [DW-1:0]           cdb_data
);
    typedef struct packed {
        logic          present;
        logic [TW-1:0] tag;
        logic [DW-1:0] val;
    } reg_entry_t;

    reg_entry_t ent_q [NREG];

    // Combinational read ports for the two sources and the observer.
    always_comb begin
        rd_a_present = ent_q[rd_a_addr].present;
        rd_a_tag     = ent_q[rd_a_addr].tag;
        rd_a_val     = ent_q[rd_a_addr].val;
        rd_b_present = ent_q[rd_b_addr].present;
        rd_b_tag     = ent_q[rd_b_addr].tag;
        rd_b_val     = ent_q[rd_b_addr].val;
        rd_o_present = ent_q[rd_o_addr].present;
        rd_o_tag     = ent_q[rd_o_addr].tag;
        rd_o_val     = ent_q[rd_o_addr].val;
    end

    // Entry update: rename on dispatch, else capture on a matching broadcast.
    always_ff @(posedge clk) begin
        for (int r = 0; r < NREG; r++) begin
            if (!rst_n) begin
                ent_q[r].present <= 1'b1;
                ent_q[r].tag     <= '0;
                ent_q[r].val     <= DW'(r);
            end else if (set_en && set_addr == r[$clog2(NREG)-1:0]) begin
                ent_q[r].present <= 1'b0;
                ent_q[r].tag     <= set_tag;
            end else if (!ent_q[r].present && cdb_valid && ent_q[r].tag == cdb_tag) begin
                ent_q[r].present <= 1'b1;
                ent_q[r].val     <= cdb_data;
            end
        end
    end

    generate
        for (genvar g = 0; g < NREG; g++) begin : g_chk
            // R3: a renamed entry is pending on the new tag one cycle later
            a_r3_rename_pending: assert property (@(posedge clk) disable iff (!rst_n)
                (set_en && set_addr == g) |=> (!ent_q[g].present && ent_q[g].tag == $past(set_tag)));
            // R4: a broadcast with a foreign tag leaves a pending entry pending
            a_r4_stale_tag_kept: assert property (@(posedge clk) disable iff (!rst_n)
                (!ent_q[g].present && cdb_valid && cdb_tag != ent_q[g].tag && !(set_en && set_addr == g))
                |=> (!ent_q[g].present && $stable(ent_q[g].tag)));
        end
    endgenerate

endmodule

// File: rtl/tsa_station_group.sv
// One group of reservation stations sharing a single non-pipelined,
// fixed-latency execution stub. Allocation takes the lowest free station.
// Waiting operands snoop the result bus. The lowest ready station issues
// when the stub is idle. The stub holds its result and requests the bus
// until granted, and the producing station is freed on its own broadcast.
// Assumes: alloc_en only when has_free; LAT >= 1; the grant is only given
// while req is high.
module tsa_station_group #(
    parameter int                  NS   = 3,
    parameter int                  DW   = 16,
    parameter int                  TW   = 3,
    parameter int                  BASE = 1,
    parameter int                  LAT  = 2,
    parameter tsa_pkg::unit_kind_e KIND = tsa_pkg::UNIT_ADD
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          alloc_en,
    input  logic          alloc_a_p,
    input  logic [TW-1:0] alloc_a_tag,
    input  logic [DW-1:0] alloc_a_val,
    input  logic          alloc_b_p,
    input  logic [TW-1:0] alloc_b_tag,
    input  logic [DW-1:0] alloc_b_val,
    output logic          has_free,
    output logic [TW-1:0] alloc_tag,
    input  logic          cdb_valid,
    input  logic [TW-1:0] cdb_tag,
    input  logic [DW-1:0] cdb_data,
    output logic          req,
    output logic [TW-1:0] req_tag,
    output logic [DW-1:0] req_data,
    input  logic          grant
);
    localparam int IW = (NS > 1) ? $clog2(NS) : 1;
    localparam int CW = $clog2(LAT + 1);

    typedef struct packed {
        logic          busy;
        logic          fired;
        logic          pa;
        logic          pb;
        logic [TW-1:0] ta;
        logic [TW-1:0] tb;
        logic [DW-1:0] va;
        logic [DW-1:0] vb;
    } slot_t;

    slot_t         st_q [NS];
    logic          free_found, pick_found, fire;
    logic [IW-1:0] free_idx, pick_idx;
    logic [DW-1:0] op_result;
    logic          u_busy_q;
    logic [CW-1:0] u_cnt_q;
    logic [DW-1:0] u_res_q;
    logic [TW-1:0] u_tag_q;

    // Lowest-index free station for allocation.
    always_comb begin
        free_found = 1'b0;
        free_idx   = '0;
        for (int s = NS - 1; s >= 0; s--) begin
            if (!st_q[s].busy) begin
                free_found = 1'b1;
                free_idx   = IW'(s);
            end
        end
    end

    // Lowest-index station with both operands present and not yet issued.
    always_comb begin
        pick_found = 1'b0;
        pick_idx   = '0;
        for (int s = NS - 1; s >= 0; s--) begin
            if (st_q[s].busy && !st_q[s].fired && st_q[s].pa && st_q[s].pb) begin
                pick_found = 1'b1;
                pick_idx   = IW'(s);
            end
        end
    end

    assign fire      = pick_found && !u_busy_q;
    assign has_free  = free_found;
    assign alloc_tag = TW'(BASE) + TW'(free_idx);

    // Arithmetic stub chosen by the group kind.
    generate
        if (KIND == tsa_pkg::UNIT_MUL) begin : g_mul
            logic [2*DW-1:0] prod;
            assign prod      = st_q[pick_idx].va * st_q[pick_idx].vb;
            assign op_result = prod[DW-1:0];
        end else begin : g_add
            assign op_result = st_q[pick_idx].va + st_q[pick_idx].vb;
        end
    endgenerate

    // Station update: allocate, free on own broadcast, snoop, mark issued.
    always_ff @(posedge clk) begin
        for (int s = 0; s < NS; s++) begin
            if (!rst_n) begin
                st_q[s] <= '0;
            end else if (alloc_en && free_idx == IW'(s)) begin
                st_q[s].busy  <= 1'b1;
                st_q[s].fired <= 1'b0;
                st_q[s].pa    <= alloc_a_p;
                st_q[s].ta    <= alloc_a_tag;
                st_q[s].va    <= alloc_a_val;
                st_q[s].pb    <= alloc_b_p;
                st_q[s].tb    <= alloc_b_tag;
                st_q[s].vb    <= alloc_b_val;
            end else if (st_q[s].busy) begin
                if (cdb_valid && cdb_tag == TW'(BASE + s)) begin
                    st_q[s].busy  <= 1'b0;
                    st_q[s].fired <= 1'b0;
                end else begin
                    if (fire && pick_idx == IW'(s)) begin
                        st_q[s].fired <= 1'b1;
                    end
                    if (!st_q[s].pa && cdb_valid && cdb_tag == st_q[s].ta) begin
                        st_q[s].pa <= 1'b1;
                        st_q[s].va <= cdb_data;
                    end
                    if (!st_q[s].pb && cdb_valid && cdb_tag == st_q[s].tb) begin
                        st_q[s].pb <= 1'b1;
                        st_q[s].vb <= cdb_data;
                    end
                end
            end
        end
    end

    // Execution stub: load on issue, count down, hold until granted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            u_busy_q <= 1'b0;
            u_cnt_q  <= '0;
            u_res_q  <= '0;
            u_tag_q  <= '0;
        end else if (!u_busy_q) begin
            if (pick_found) begin
                u_busy_q <= 1'b1;
                u_cnt_q  <= CW'(LAT - 1);
                u_res_q  <= op_result;
                u_tag_q  <= TW'(BASE) + TW'(pick_idx);
            end
        end else if (grant) begin
            u_busy_q <= 1'b0;
        end else if (u_cnt_q != '0) begin
            u_cnt_q <= u_cnt_q - 1'b1;
        end
    end

    assign req      = u_busy_q && (u_cnt_q == '0);
    assign req_tag  = u_tag_q;
    assign req_data = u_res_q;

    // R2: the top never allocates into a full group
    a_r2_alloc_has_room: assert property (@(posedge clk) disable iff (!rst_n)
        alloc_en |-> has_free);
    // R9: a result that is refused keeps requesting with the same tag and value
    a_r9_hold_until_grant: assert property (@(posedge clk) disable iff (!rst_n)
        (req && !grant) |=> (req && $stable(req_data) && $stable(req_tag)));

    generate
        for (genvar g = 0; g < NS; g++) begin : g_chk
            // R10: a station is free right after its own broadcast
            a_r10_free_after_bcast: assert property (@(posedge clk) disable iff (!rst_n)
                (cdb_valid && cdb_tag == TW'(BASE + g)) |=> !st_q[g].busy);
            // R5: a waiting operand takes the value of a matching broadcast
            a_r5_snoop_capture: assert property (@(posedge clk) disable iff (!rst_n)
                (st_q[g].busy && !st_q[g].pa && cdb_valid && cdb_tag == st_q[g].ta)
                |=> (st_q[g].pa && st_q[g].va == $past(cdb_data)));
        end
    endgenerate

endmodule

// File: rtl/tsa_cdb_arbiter.sv
// Single result bus arbiter. The multiplier group has priority over the
// adder group, and the bus carries the granted request unchanged.
// Assumes: the request inputs are stable for the whole cycle.
module tsa_cdb_arbiter #(
    parameter int DW = 16,
    parameter int TW = 3
) (
    input  logic          add_req,
    input  logic [TW-1:0] add_tag,
    input  logic [DW-1:0] add_data,
    input  logic          mul_req,
    input  logic [TW-1:0] mul_tag,
    input  logic [DW-1:0] mul_data,
    output logic          add_grant,
    output logic          mul_grant,
    output logic          cdb_valid,
    output logic [TW-1:0] cdb_tag,
    output logic [DW-1:0] cdb_data
);
    // Fixed-priority grant and bus multiplexer.
    always_comb begin
        mul_grant = mul_req;
        add_grant = add_req && !mul_req;
        cdb_valid = add_req || mul_req;
        cdb_tag   = mul_req ? mul_tag  : add_tag;
        cdb_data  = mul_req ? mul_data : add_data;
    end

    // R9: never two grants at once
    always_comb begin
        a_r9_single_grant: assert ($onehot0({add_grant, mul_grant}));
    end

endmodule

// File: rtl/tag_station_array.sv
// Top of the tag-matching reservation station array. It resolves the source
// operands of a dispatch from the register status table, or straight from
// the bus when the producer broadcasts in the same cycle. It steers the
// operation to the adder or the multiplier group, renames the destination
// and arbitrates the shared result bus.
// Assumes: disp_* are held stable while disp_valid is high within a cycle.
module tag_station_array #(
    parameter int NREG    = 8,
    parameter int DW      = 16,
    parameter int N_ADD   = 3,
    parameter int N_MUL   = 2,
    parameter int ADD_LAT = 2,
    parameter int MUL_LAT = 3
) (
    input  logic                                     clk,
    input  logic                                     rst_n,
    input  logic                                     disp_valid,
    input  logic                                     disp_is_mul,
    input  logic [$clog2(NREG)-1:0]                  disp_dst,
    input  logic [$clog2(NREG)-1:0]                  disp_src_a,
    input  logic [$clog2(NREG)-1:0]                  disp_src_b,
    output logic                                     disp_ready,
    output logic                                     cdb_valid,
    output logic [tsa_pkg::tag_bits(N_ADD+N_MUL)-1:0] cdb_tag,
    output logic [DW-1:0]                            cdb_data,
    input  logic [$clog2(NREG)-1:0]                  rf_raddr,
    output logic                                     rf_rpresent,
    output logic [tsa_pkg::tag_bits(N_ADD+N_MUL)-1:0] rf_rtag,
    output logic [DW-1:0]                            rf_rdata
);
    localparam int TW = tsa_pkg::tag_bits(N_ADD + N_MUL);

    logic          ra_p, rb_p;
    logic [TW-1:0] ra_t, rb_t;
    logic [DW-1:0] ra_v, rb_v;
    logic          oa_p, ob_p;
    logic [TW-1:0] oa_t, ob_t;
    logic [DW-1:0] oa_v, ob_v;
    logic          add_free, mul_free, accept;
    logic [TW-1:0] add_atag, mul_atag, new_tag;
    logic          add_req, mul_req, add_grant, mul_grant;
    logic [TW-1:0] add_rtag, mul_rtag;
    logic [DW-1:0] add_rdata, mul_rdata;

    assign disp_ready = disp_is_mul ? mul_free : add_free;
    assign accept     = disp_valid && disp_ready;
    assign new_tag    = disp_is_mul ? mul_atag : add_atag;

    tsa_reg_status #(.NREG(NREG), .DW(DW), .TW(TW)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .rd_a_addr(disp_src_a), .rd_a_present(ra_p), .rd_a_tag(ra_t), .rd_a_val(ra_v),
        .rd_b_addr(disp_src_b), .rd_b_present(rb_p), .rd_b_tag(rb_t), .rd_b_val(rb_v),
        .rd_o_addr(rf_raddr), .rd_o_present(rf_rpresent), .rd_o_tag(rf_rtag), .rd_o_val(rf_rdata),
        .set_en(accept), .set_addr(disp_dst), .set_tag(new_tag),
        .cdb_valid(cdb_valid), .cdb_tag(cdb_tag), .cdb_data(cdb_data)
    );

    // Source operand resolution with same-cycle bus bypass.
    always_comb begin
        oa_p = 1'b1; oa_t = '0; oa_v = ra_v;
        if (!ra_p) begin
            if (cdb_valid && cdb_tag == ra_t) begin
                oa_v = cdb_data;
            end else begin
                oa_p = 1'b0; oa_t = ra_t; oa_v = '0;
            end
        end
        ob_p = 1'b1; ob_t = '0; ob_v = rb_v;
        if (!rb_p) begin
            if (cdb_valid && cdb_tag == rb_t) begin
                ob_v = cdb_data;
            end else begin
                ob_p = 1'b0; ob_t = rb_t; ob_v = '0;
            end
        end
    end

    tsa_station_group #(.NS(N_ADD), .DW(DW), .TW(TW), .BASE(1), .LAT(ADD_LAT),
                        .KIND(tsa_pkg::UNIT_ADD)) u_add (
        .clk(clk), .rst_n(rst_n), .alloc_en(accept && !disp_is_mul),
        .alloc_a_p(oa_p), .alloc_a_tag(oa_t), .alloc_a_val(oa_v),
        .alloc_b_p(ob_p), .alloc_b_tag(ob_t), .alloc_b_val(ob_v),
        .has_free(add_free), .alloc_tag(add_atag),
        .cdb_valid(cdb_valid), .cdb_tag(cdb_tag), .cdb_data(cdb_data),
        .req(add_req), .req_tag(add_rtag), .req_data(add_rdata), .grant(add_grant)
    );

    tsa_station_group #(.NS(N_MUL), .DW(DW), .TW(TW), .BASE(1 + N_ADD), .LAT(MUL_LAT),
                        .KIND(tsa_pkg::UNIT_MUL)) u_mul (
        .clk(clk), .rst_n(rst_n), .alloc_en(accept && disp_is_mul),
        .alloc_a_p(oa_p), .alloc_a_tag(oa_t), .alloc_a_val(oa_v),
        .alloc_b_p(ob_p), .alloc_b_tag(ob_t), .alloc_b_val(ob_v),
        .has_free(mul_free), .alloc_tag(mul_atag),
        .cdb_valid(cdb_valid), .cdb_tag(cdb_tag), .cdb_data(cdb_data),
        .req(mul_req), .req_tag(mul_rtag), .req_data(mul_rdata), .grant(mul_grant)
    );

    tsa_cdb_arbiter #(.DW(DW), .TW(TW)) u_arb (
        .add_req(add_req), .add_tag(add_rtag), .add_data(add_rdata),
        .mul_req(mul_req), .mul_tag(mul_rtag), .mul_data(mul_rdata),
        .add_grant(add_grant), .mul_grant(mul_grant),
        .cdb_valid(cdb_valid), .cdb_tag(cdb_tag), .cdb_data(cdb_data)
    );

    // R1: a broadcast always names an allocated tag, never the reserved 0
    a_r1_tag_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        cdb_valid |-> (cdb_tag != '0 && cdb_tag <= TW'(N_ADD + N_MUL)));

endmodule

// File: tb/tag_station_array_tb.sv
// Bench: behavioural reference model compared on every clock, plus directed
// sequences for stalls, bypass, stale tags and bus conflicts.
module tag_station_array_tb_top;
    localparam int NREG = 8, DW = 16, NA = 3, NM = 2, LA = 2, LM = 3;
    localparam int NT = NA + NM;
    localparam int RW = $clog2(NREG);
    localparam int TW = $clog2(NT + 1);
    localparam longint MASK = (64'd1 << DW) - 1;

    logic clk = 1'b0, rst_n = 1'b0;
    logic disp_valid = 1'b0, disp_is_mul = 1'b0;
    logic [RW-1:0] disp_dst = '0, disp_src_a = '0, disp_src_b = '0, rf_raddr = '0;
    logic disp_ready, cdb_valid, rf_rpresent;
    logic [TW-1:0] cdb_tag, rf_rtag;
    logic [DW-1:0] cdb_data, rf_rdata;

    int n_checks = 0, n_fails = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    tag_station_array #(.NREG(NREG), .DW(DW), .N_ADD(NA), .N_MUL(NM),
                        .ADD_LAT(LA), .MUL_LAT(LM)) dut_i (
        .clk(clk), .rst_n(rst_n), .disp_valid(disp_valid), .disp_is_mul(disp_is_mul),
        .disp_dst(disp_dst), .disp_src_a(disp_src_a), .disp_src_b(disp_src_b),
        .disp_ready(disp_ready), .cdb_valid(cdb_valid), .cdb_tag(cdb_tag),
        .cdb_data(cdb_data), .rf_raddr(rf_raddr), .rf_rpresent(rf_rpresent),
        .rf_rtag(rf_rtag), .rf_rdata(rf_rdata)
    );

    // Reference model state (index 1..NT are tags; group 0 adder, 1 multiplier)
    int s_busy[NT+1], s_fired[NT+1], s_pa[NT+1], s_pb[NT+1], s_ta[NT+1], s_tb[NT+1];
    longint s_va[NT+1], s_vb[NT+1];
    int r_p[NREG], r_t[NREG];
    longint r_v[NREG];
    int u_busy[2], u_cnt[2], u_tag[2];
    longint u_res[2];
    int m_ready, m_bv, m_bt, m_gnt;
    longint m_bd;

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int t = 0; t <= NT; t++) begin
            s_busy[t] = 0; s_fired[t] = 0; s_pa[t] = 0; s_pb[t] = 0;
            s_ta[t] = 0; s_tb[t] = 0; s_va[t] = 0; s_vb[t] = 0;
        end
        for (int r = 0; r < NREG; r++) begin r_p[r] = 1; r_t[r] = 0; r_v[r] = r; end
        for (int g = 0; g < 2; g++) begin u_busy[g] = 0; u_cnt[g] = 0; u_tag[g] = 0; u_res[g] = 0; end
    endtask

    function automatic int lowest_free(input int g);
        int lo = (g == 0) ? 1 : NA + 1;
        int hi = (g == 0) ? NA : NT;
        for (int t = lo; t <= hi; t++) if (s_busy[t] == 0) return t;
        return 0;
    endfunction

    // Outputs the model predicts for the current state and inputs.
    task automatic model_comb(input bit ism);
        bit rq_a = (u_busy[0] != 0) && (u_cnt[0] == 0);
        bit rq_m = (u_busy[1] != 0) && (u_cnt[1] == 0);
        m_ready = (lowest_free(ism ? 1 : 0) != 0);
        m_bv = rq_a || rq_m;
        m_gnt = rq_m ? 1 : (rq_a ? 0 : -1);
        m_bt = (m_gnt >= 0) ? u_tag[m_gnt] : 0;
        m_bd = (m_gnt >= 0) ? u_res[m_gnt] : 0;
    endtask

    // State after the next rising edge.
    task automatic model_next(input bit dv, input bit ism, input int dst, input int sa, input int sb);
        int at = lowest_free(ism ? 1 : 0);
        bit acc = dv && (at != 0);
        int ap, bp, atg, btg;
        longint av, bvv;
        ap = 1; atg = 0; av = r_v[sa];
        if (r_p[sa] == 0) begin
            if (m_bv && r_t[sa] == m_bt) av = m_bd;
            else begin ap = 0; atg = r_t[sa]; av = 0; end
        end
        bp = 1; btg = 0; bvv = r_v[sb];
        if (r_p[sb] == 0) begin
            if (m_bv && r_t[sb] == m_bt) bvv = m_bd;
            else begin bp = 0; btg = r_t[sb]; bvv = 0; end
        end
        for (int g = 0; g < 2; g++) begin
            if (u_busy[g] == 0) begin
                int lo = (g == 0) ? 1 : NA + 1;
                int hi = (g == 0) ? NA : NT;
                for (int t = lo; t <= hi; t++) begin
                    if (s_busy[t] != 0 && s_fired[t] == 0 && s_pa[t] != 0 && s_pb[t] != 0) begin
                        s_fired[t] = 1; u_busy[g] = 1; u_cnt[g] = ((g == 0) ? LA : LM) - 1;
                        u_res[g] = (g == 0) ? ((s_va[t] + s_vb[t]) & MASK) : ((s_va[t] * s_vb[t]) & MASK);
                        u_tag[g] = t;
                        break;
                    end
                end
            end else if (m_gnt == g) u_busy[g] = 0;
            else if (u_cnt[g] > 0) u_cnt[g]--;
        end
        if (m_bv) begin
            for (int t = 1; t <= NT; t++) begin
                if (s_busy[t] != 0) begin
                    if (t == m_bt) begin s_busy[t] = 0; s_fired[t] = 0; end
                    else begin
                        if (s_pa[t] == 0 && s_ta[t] == m_bt) begin s_pa[t] = 1; s_va[t] = m_bd; end
                        if (s_pb[t] == 0 && s_tb[t] == m_bt) begin s_pb[t] = 1; s_vb[t] = m_bd; end
                    end
                end
            end
            for (int r = 0; r < NREG; r++)
                if (r_p[r] == 0 && r_t[r] == m_bt) begin r_p[r] = 1; r_v[r] = m_bd; end
        end
        if (acc) begin
            s_busy[at] = 1; s_fired[at] = 0;
            s_pa[at] = ap; s_ta[at] = atg; s_va[at] = av;
            s_pb[at] = bp; s_tb[at] = btg; s_vb[at] = bvv;
            r_p[dst] = 0; r_t[dst] = at;
        end
    endtask

    // One clock: drive at the falling edge, compare, advance the model.
    task automatic step(input bit dv, input bit ism, input int dst, input int sa, input int sb, input int ra);
        @(negedge clk);
        disp_valid = dv; disp_is_mul = ism;
        disp_dst = RW'(dst); disp_src_a = RW'(sa); disp_src_b = RW'(sb); rf_raddr = RW'(ra);
        #1;
        model_comb(ism);
        chk(disp_ready == m_ready[0], "R2 disp_ready", disp_ready, m_ready);
        chk(cdb_valid == m_bv[0], "R9 cdb_valid", cdb_valid, m_bv);
        if (m_bv != 0) begin
            chk(cdb_tag == TW'(m_bt), "R7 cdb_tag", cdb_tag, m_bt);
            chk(cdb_data == DW'(m_bd), "R8 cdb_data", cdb_data, m_bd);
        end
        chk(rf_rpresent == r_p[ra][0], "R3 rf_rpresent", rf_rpresent, r_p[ra]);
        if (r_p[ra] == 0) chk(rf_rtag == TW'(r_t[ra]), "R1 rf_rtag", rf_rtag, r_t[ra]);
        else chk(rf_rdata == DW'(r_v[ra]), "R4 rf_rdata", rf_rdata, r_v[ra]);
        model_next(dv, ism, dst, sa, sb);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(1'b0, 1'b0, 0, 0, 0, i % NREG);
    endtask

    initial begin
        int lat;
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        #1;
        // R11: reset state
        chk(disp_ready == 1'b1, "R11 disp_ready", disp_ready, 1);
        chk(cdb_valid == 1'b0, "R11 cdb_valid", cdb_valid, 0);
        for (int r = 0; r < NREG; r++) begin
            step(1'b0, 1'b0, 0, 0, 0, r);
            chk(rf_rpresent && rf_rdata == DW'(r), "R11 reg value", rf_rdata, r);
        end

        // R1/R8: add r1 = r2 + r3 takes tag 1, result 5 after ADD_LAT
        step(1'b1, 1'b0, 1, 2, 3, 0);
        lat = 0;
        for (int i = 0; i < 10; i++) begin
            step(1'b0, 1'b0, 0, 0, 0, 1);
            lat++;
            if (cdb_valid) break;
        end
        chk(cdb_tag == 1, "R1 first adder tag", cdb_tag, 1);
        chk(cdb_data == 5, "R8 sum", cdb_data, 5);
        chk(lat == LA + 1, "R8 latency", lat, LA + 1);
        idle(6);

        // R5/R6: mul r4 = r2*r3 (tag NA+1); r5 = r4+r4 waits; r6 = r4+r2 dispatched on the broadcast
        step(1'b1, 1'b1, 4, 2, 3, 0);
        step(1'b1, 1'b0, 5, 4, 4, 4);
        chk(!rf_rpresent && rf_rtag == NA + 1, "R1 multiplier tag", rf_rtag, NA + 1);
        step(1'b0, 1'b0, 0, 0, 0, 0);
        step(1'b0, 1'b0, 0, 0, 0, 0);
        step(1'b1, 1'b0, 6, 4, 2, 0);
        chk(cdb_valid && cdb_tag == NA + 1, "R6 producer broadcasting", cdb_tag, NA + 1);
        idle(12);
        step(1'b0, 1'b0, 0, 0, 0, 5);
        chk(rf_rpresent && rf_rdata == 12, "R5 waiting operand filled", rf_rdata, 12);
        step(1'b0, 1'b0, 0, 0, 0, 6);
        chk(rf_rpresent && rf_rdata == 8, "R6 bypass at dispatch", rf_rdata, 8);

        // R2/R10: fill all adder stations, stall, then reuse the freed station
        step(1'b1, 1'b0, 7, 1, 1, 0);
        step(1'b1, 1'b0, 7, 1, 1, 0);
        step(1'b1, 1'b0, 7, 1, 1, 0);
        step(1'b1, 1'b0, 0, 1, 1, 0);
        chk(disp_ready == 1'b0, "R2 stall on full adder group", disp_ready, 0);
        chk(cdb_valid && cdb_tag == 1, "R10 tag 1 broadcasting", cdb_tag, 1);
        step(1'b1, 1'b0, 0, 1, 1, 0);
        chk(disp_ready == 1'b1, "R10 station reusable", disp_ready, 1);
        step(1'b0, 1'b0, 0, 0, 0, 0);
        chk(!rf_rpresent && rf_rtag == 1, "R10 reallocated tag", rf_rtag, 1);
        idle(20);

        // R4: r3 renamed to a multiply before the older add result arrives
        step(1'b1, 1'b0, 3, 1, 1, 0);
        step(1'b1, 1'b1, 3, 1, 1, 0);
        step(1'b0, 1'b0, 0, 0, 0, 3);
        step(1'b0, 1'b0, 0, 0, 0, 3);
        chk(cdb_valid && cdb_tag == 1, "R4 older producer broadcasting", cdb_tag, 1);
        step(1'b0, 1'b0, 0, 0, 0, 3);
        chk(!rf_rpresent && rf_rtag == NA + 1, "R4 stale broadcast ignored", rf_rtag, NA + 1);
        idle(8);
        step(1'b0, 1'b0, 0, 0, 0, 3);
        chk(rf_rpresent && rf_rdata == 25, "R4 newer value", rf_rdata, 25);

        // R9: multiplier and adder request together; the multiplier goes first
        step(1'b1, 1'b1, 7, 1, 2, 0);
        step(1'b1, 1'b0, 6, 1, 2, 0);
        step(1'b0, 1'b0, 0, 0, 0, 0);
        step(1'b0, 1'b0, 0, 0, 0, 0);
        step(1'b0, 1'b0, 0, 0, 0, 0);
        chk(cdb_valid && cdb_tag == NA + 1, "R9 multiplier wins", cdb_tag, NA + 1);
        step(1'b0, 1'b0, 0, 0, 0, 0);
        chk(cdb_valid && cdb_tag == 1, "R9 adder follows", cdb_tag, 1);
        idle(10);

        // R7 and the rest: random stream against the model
        for (int i = 0; i < 4000; i++)
            step(($urandom % 3) != 0, $urandom % 2, $urandom % NREG, $urandom % NREG,
                 $urandom % NREG, i % NREG);
        idle(40);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
        $finish;
    end

    initial begin
        #2000000;
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
            $finish;
        end
    end

endmodule